// File: doc/BRIEF.md
# Counter-Sequenced Flag Controller

This block pairs a three-state controller with a small datapath: a 4-bit up-counter and two one-bit flags, here called the steer flag (E) and the finish flag (F). A pulse on `start` while the block is idle begins a run. Starting a run clears the counter and the finish flag. The counter then advances by one on every clock. On each counting clock the two upper counter bits act as status inputs to the controller. The lower of the two decides the new value of the steer flag. The two together decide when counting ends.

When both upper bits are set, the controller moves to a stop state for one clock. In that clock it raises the finish flag. It then falls back to idle, and the counter keeps its last value. The present state is shown on a one-hot output and on a busy pin. The block has no data stream, so all of its pins are plain level signals with no handshake.

The counter bits are numbered from the least significant, bit index 0 (A1), up to bit index 3 (A4). A3 is bit index 2. Every decision uses the counter value held before that clock's increment. A run started from idle therefore counts from 0 up to 12 over 13 clocks and leaves the counter at 13. The stop clock follows.

Top module: `flagseq_ctrl`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising edge forces the idle state and clears the counter, the steer flag and the finish flag. After that edge `state_oh_o` is 3'b001 and `busy_o` is 0.
- R2: In idle with `start` low, the counter and both flags keep their values and the block stays idle.
- R3: In idle with `start` high, the next edge clears the counter and the finish flag and enters the counting state. The steer flag is unchanged.
- R4: In the counting state the counter increases by exactly one, modulo 16, at every edge.
- R5: In the counting state each edge loads the steer flag with the pre-increment counter bit at index 2 (A3). The flag is cleared when that bit is 0 and set when it is 1.
- R6: In the counting state the controller moves to the stop state only when the pre-increment counter bits at indices 3 and 2 are both 1. Otherwise it stays in the counting state.
- R7: In the stop state the next edge sets the finish flag, leaves the counter unchanged and returns to idle.
- R8: `start` has no effect outside the idle state.
- R9: `state_oh_o` always has exactly one bit set. Bit 0 means idle, bit 1 means counting and bit 2 means stop. `busy_o` is high exactly when the block is not idle.
- R10: A run started from idle ends in idle with the counter at 13, the steer flag at 1 and the finish flag at 1. The run takes 13 counting clocks and one stop clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a run; sampled only in idle |
| count_o | output | 4 | Counter value |
| e_o | output | 1 | Steer flag (E) |
| f_o | output | 1 | Finish flag (F) |
| busy_o | output | 1 | High while counting or stopping |
| state_oh_o | output | 3 | One-hot state: bit0 idle, bit1 counting, bit2 stop |

## Verification
Every output is registered or decoded from registers. The effect of a `start`, a reset or a counting step therefore shows on the pins exactly one rising edge after the inputs that caused it. The finish flag rises 14 edges after the start edge. The driver sets inputs on the falling edge and pushes the state it predicts after the next rising edge. The monitor compares that prediction 1 ns after the rising edge, one entry per cycle, so no result is read on the edge where it changes.

// File: rtl/flagseq_pkg.sv
package flagseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_COUNT = 2'b01,
    ST_STOP  = 2'b11
  } fs_state_t;

  localparam int unsigned N_STATES = 3;
endpackage

// File: rtl/flagseq_next.sv
module flagseq_next
  import flagseq_pkg::*;
(
  input  fs_state_t cur_state,
  input  logic      start,
  input  logic      steer_bit,
  input  logic      stop_bit,
  output fs_state_t nxt_state
);
  // Next-state selection, one arm per present state.
  always_comb begin
    nxt_state = ST_IDLE;
    case (cur_state)
      ST_IDLE:  nxt_state = start ? ST_COUNT : ST_IDLE;
      ST_COUNT: nxt_state = (steer_bit && stop_bit) ? ST_STOP : ST_COUNT;
      ST_STOP:  nxt_state = ST_IDLE;
      default:  nxt_state = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/flagseq_decode.sv
module flagseq_decode
  import flagseq_pkg::*;
(
  input  fs_state_t             cur_state,
  output logic [N_STATES-1:0]   state_oh
);
  localparam fs_state_t CODES [N_STATES] = '{ST_IDLE, ST_COUNT, ST_STOP};

  for (genvar i = 0; i < N_STATES; i++) begin : g_dec
    assign state_oh[i] = (cur_state == CODES[i]);
  end
endmodule

// File: rtl/flagseq_datapath.sv
module flagseq_datapath #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  input  logic             set_f,
  output logic [CNT_W-1:0] count,
  output logic             e_flag,
  output logic             f_flag
);
  localparam int unsigned STEER_IDX = CNT_W - 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      e_flag <= 1'b0;
      f_flag <= 1'b0;
    end else begin
      if (clr) begin
        count  <= '0;
        f_flag <= 1'b0;
      end else if (inc) begin
        count  <= count + 1'b1;
        e_flag <= count[STEER_IDX];
      end
      if (set_f) f_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/flagseq_ctrl.sv
module flagseq_ctrl
  import flagseq_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic [CNT_W-1:0] count_o,
  output logic             e_o,
  output logic             f_o,
  output logic             busy_o,
  output logic [2:0]       state_oh_o
);
  localparam int unsigned STEER_IDX = CNT_W - 2;
  localparam int unsigned STOP_IDX  = CNT_W - 1;

  fs_state_t          state_q, state_d;
  logic [N_STATES-1:0] oh;
  logic [CNT_W-1:0]   cnt;

  flagseq_next u_next (
    .cur_state (state_q),
    .start     (start),
    .steer_bit (cnt[STEER_IDX]),
    .stop_bit  (cnt[STOP_IDX]),
    .nxt_state (state_d)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  flagseq_decode u_dec (
    .cur_state (state_q),
    .state_oh  (oh)
  );

  flagseq_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .clr    (oh[0] & start),
    .inc    (oh[1]),
    .set_f  (oh[2]),
    .count  (cnt),
    .e_flag (e_o),
    .f_flag (f_o)
  );

  assign count_o    = cnt;
  assign state_oh_o = oh;
  assign busy_o     = ~oh[0];
endmodule

// File: rtl/flagseq_ctrl_chk.sv
module flagseq_ctrl_chk #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [CNT_W-1:0] count_o,
  input logic             e_o,
  input logic             f_o,
  input logic             busy_o,
  input logic [2:0]       state_oh_o
);
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (state_oh_o == 3'b001 && count_o == '0 && !e_o && !f_o));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (state_oh_o[0] && !start) |=> (state_oh_o[0] && $stable(count_o) && $stable(e_o) && $stable(f_o)));

  a_r3_start_clears: assert property (@(posedge clk) disable iff (rst)
    (state_oh_o[0] && start) |=> (state_oh_o[1] && count_o == '0 && !f_o && $stable(e_o)));

  a_r4_increment: assert property (@(posedge clk) disable iff (rst)
    state_oh_o[1] |=> (count_o == $past(count_o) + 1'b1));

  a_r5_steer_flag: assert property (@(posedge clk) disable iff (rst)
    state_oh_o[1] |=> (e_o == $past(count_o[CNT_W-2])));

  a_r6_stop_decision: assert property (@(posedge clk) disable iff (rst)
    state_oh_o[1] |=> (state_oh_o[2] == ($past(count_o[CNT_W-1]) && $past(count_o[CNT_W-2]))));

  a_r7_stop_state: assert property (@(posedge clk) disable iff (rst)
    state_oh_o[2] |=> (state_oh_o[0] && f_o && $stable(count_o)));

  a_r9_onehot_busy: assert property (@(posedge clk) disable iff (rst)
    ($countones(state_oh_o) == 1) && (busy_o == !state_oh_o[0]));
endmodule

bind flagseq_ctrl flagseq_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .count_o    (count_o),
  .e_o        (e_o),
  .f_o        (f_o),
  .busy_o     (busy_o),
  .state_oh_o (state_oh_o)
);

// File: tb/flagseq_ctrl_bench.sv
`timescale 1ns/1ps
module flagseq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [3:0] count_o;
  logic       e_o, f_o, busy_o;
  logic [2:0] state_oh_o;

  always #2.5 clk = ~clk;

  flagseq_ctrl u_flagseq_ctrl (
    .clk(clk), .rst(rst), .start(start), .count_o(count_o),
    .e_o(e_o), .f_o(f_o), .busy_o(busy_o), .state_oh_o(state_oh_o)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // reference model: 0 idle, 1 counting, 2 stop
  int         m_st = 0;
  logic [3:0] m_a = '0;
  logic       m_e = 1'b0, m_f = 1'b0;

  logic [9:0] exp_q[$];
  string      tag_q[$];

  function automatic logic [9:0] pack_model();
    logic [2:0] oh;
    oh = (m_st == 0) ? 3'b001 : (m_st == 1) ? 3'b010 : 3'b100;
    return {oh, (m_st != 0), m_f, m_e, m_a};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; start = 1'b0;
    m_st = 0; m_a = '0; m_e = 1'b0; m_f = 1'b0;
    exp_q.push_back(pack_model()); tag_q.push_back("R1");
  endtask

  task automatic step(input logic s);
    string tg;
    @(negedge clk);
    rst = 1'b0; start = s;
    case (m_st)
      0: begin
        if (s) begin tg = "R3"; m_a = '0; m_f = 1'b0; m_st = 1; end
        else tg = "R2";
      end
      1: begin
        tg = s ? "R8" : "R4 R5 R6";
        m_e = m_a[2];
        if (m_a[3] && m_a[2]) m_st = 2;
        m_a = m_a + 1'b1;
      end
      default: begin
        tg = s ? "R8" : "R7";
        m_f = 1'b1; m_st = 0;
      end
    endcase
    exp_q.push_back(pack_model()); tag_q.push_back(tg);
  endtask

  // monitor: compare 1 ns after each rising edge
  always @(posedge clk) begin
    logic [9:0] ex, act;
    string      tg;
    #1;
    if (exp_q.size() > 0) begin
      ex = exp_q.pop_front(); tg = tag_q.pop_front();
      act = {state_oh_o, busy_o, f_o, e_o, count_o};
      n_vec++;
      if (act !== ex) begin
        n_bad++;
        $display("FAIL %s: {oh,busy,f,e,count} actual=%b expected=%b", tg, act, ex);
      end
      n_vec++;
      if ($countones(state_oh_o) != 1 || busy_o !== !state_oh_o[0]) begin
        n_bad++;
        $display("FAIL R9: oh/busy actual=%b/%b expected one-hot, busy=!oh[0]", state_oh_o, busy_o);
      end
    end
  end

  task automatic check_done();
    @(negedge clk);
    n_vec++;
    if ({state_oh_o, count_o, e_o, f_o} !== {3'b001, 4'd13, 1'b1, 1'b1}) begin
      n_bad++;
      $display("FAIL R10: {oh,count,e,f} actual=%b expected=%b",
               {state_oh_o, count_o, e_o, f_o}, {3'b001, 4'd13, 1'b1, 1'b1});
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    do_reset(); do_reset();                       // R1
    for (int i = 0; i < 3; i++) step(1'b0);       // R2
    step(1'b1);                                   // R3
    for (int i = 0; i < 5; i++) step(1'b0);       // R4 R5
    for (int i = 0; i < 3; i++) step(1'b1);       // R8 during counting
    for (int i = 0; i < 5; i++) step(1'b0);       // R6: reaches 12, stops
    step(1'b1);                                   // R8 in stop state, R7
    for (int i = 0; i < 3; i++) step(1'b0);       // R2 after run
    check_done();                                 // R10
    step(1'b1);                                   // R3 from a nonzero count
    for (int i = 0; i < 6; i++) step(1'b0);
    do_reset();                                   // R1 mid-run
    step(1'b0);
    step(1'b1);
    for (int i = 0; i < 18; i++) step(1'b0);      // full run, R7
    check_done();                                 // R10
    repeat (3) @(negedge clk);
    finished = 1'b1;
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      report();
    end
  end
endmodule